// File: doc/BRIEF.md
# Physical Timer Control Register with Interrupt

This block sits beside one core and holds the control word of a physical countdown timer, the signed countdown value, and the level interrupt that the two produce. Software loads the countdown value and sets the control word through a simple register port. The countdown value is decremented once for every tick pulse that arrives from an external system counter. The block compares the value against zero and raises the interrupt when the condition holds, when the timer is enabled and when the interrupt is not masked.

The control word is 64 bits wide and has three live fields. The enable bit is bit 0 and the mask bit is bit 1. Bit 2 is a status flag that software can only read. The status flag shows the raw timer condition and ignores the mask. Clearing the enable bit silences only the status flag and the interrupt. The countdown value keeps moving on every tick, so software can later read the elapsed time.

Top module: `ptimer_ctrl`

## Requirements
- R1: After reset the enable and mask bits are 0, the countdown value is 0, the control word reads 0 and `irq_out` is 0.
- R2: Control word bits [63:3] always read as zero. Writes to those bits are discarded.
- R3: Bit 2 of the control word is read-only. The value written to bit 2 has no effect on any readback or on `irq_out`.
- R4: While enable (bit 0) is 1, bit 2 reads 1 exactly when the countdown value, taken as a signed 32-bit number, is less than or equal to zero. This holds for either value of mask (bit 1).
- R5: `irq_out` is a register. In the cycle after any clock edge it equals the value of enable AND status AND NOT mask that the block held in the cycle before that edge, so it follows a change one cycle late.
- R6: While enable is 0, bit 2 reads 0, and from the following cycle on `irq_out` is 0, whatever the countdown value and the mask.
- R7: A write with `wr_sel`=1 loads `wr_data[31:0]` into the countdown value. A read with `rd_sel`=1 returns that value sign-extended to 64 bits. A read with `rd_sel`=0 returns the control word.
- R8: Each cycle with `tick`=1 decrements the countdown value by one. This happens whether enable is 1 or 0, and the value wraps from 0x80000000 to 0x7FFFFFFF.
- R9: When a countdown value write and a tick fall in the same cycle, the written value is stored and the tick is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick | input | 1 | Decrement pulse from the system counter, one cycle wide |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | Write target: 0 selects the control word, 1 selects the countdown value |
| wr_data | input | 64 | Write data |
| rd_sel | input | 1 | Read target: 0 selects the control word, 1 selects the countdown value |
| rd_data | output | 64 | Combinational read data |
| irq_out | output | 1 | Registered level-sensitive timer interrupt |

## Verification
The bench steps the countdown value through the signed boundary cases: positive values, 1, 0, -1, the most negative value and the most positive value, with each combination of mask and enable. A design that compares the value as unsigned, or that tests for less-than where less-than-or-equal is required, reads the wrong status at 0 or at 0x80000000. The bench also ticks the counter while the timer is disabled and across the signed wrap, and it ticks in the same cycle as a load. A design that stops counting while disabled, or that lets the tick win over the load, reads back the wrong value. The bench samples the interrupt in the cycle just after the condition becomes true and again one cycle later. This catches a combinational interrupt path, and it also catches a status flag that is wrongly masked.

// File: rtl/ptimer_pkg.sv
package ptimer_pkg;
  localparam int CTRL_W   = 64;
  localparam int TVAL_W   = 32;
  localparam int EN_BIT   = 0;
  localparam int MASK_BIT = 1;
  localparam int STAT_BIT = 2;
  localparam int LIVE_W   = STAT_BIT + 1;

  typedef enum logic {
    SEL_CTRL = 1'b0,
    SEL_TVAL = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/ptimer_ctrl_bits.sv
module ptimer_ctrl_bits (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_ctrl,
  input  logic wr_en_bit,
  input  logic wr_mask_bit,
  output logic en_q,
  output logic mask_q
);
  logic en_d, mask_d;

  // next state: only the two writable fields; bit 2 and up are never stored
  always_comb begin
    en_d   = en_q;
    mask_d = mask_q;
    if (wr_ctrl) begin
      en_d   = wr_en_bit;
      mask_d = wr_mask_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mask_q <= 1'b0;
    end else if (wr_ctrl) begin
      en_q   <= en_d;
      mask_q <= mask_d;
    end
  end
endmodule

// File: rtl/ptimer_downcount.sv
module ptimer_downcount #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  output logic [W-1:0] val_q
);
  logic [W-1:0] val_d;
  logic         val_ce;

  // a load takes priority over a tick in the same cycle
  always_comb begin
    val_ce = load | tick;
    if (load) val_d = load_val;
    else      val_d = val_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      val_q <= '0;
    else if (val_ce) val_q <= val_d;
  end
endmodule

// File: rtl/ptimer_irq_out.sv
module ptimer_irq_out #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         mask,
  input  logic [W-1:0] val,
  output logic         status,
  output logic         irq_q
);
  logic cond_met;
  logic irq_d;

  // signed value <= 0: sign bit set, or all bits clear
  always_comb begin
    cond_met = val[W-1] | (val == '0);
    status   = en & cond_met;
    irq_d    = status & ~mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end
endmodule

// File: rtl/ptimer_ctrl.sv
module ptimer_ctrl
  import ptimer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              rd_sel,
  output logic [CTRL_W-1:0] rd_data,
  output logic              irq_out
);
  localparam int EXT_W = CTRL_W - TVAL_W;
  localparam int RSV_W = CTRL_W - LIVE_W;

  logic [1:0]        rst_sync;
  logic              rst_s;
  logic              ctrl_en, ctrl_mask, stat;
  logic [TVAL_W-1:0] tval_q;
  logic              wr_ctrl, wr_tval;
  logic              unused_hi;

  // reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s = rst_sync[1];

  assign wr_ctrl   = wr_en & (reg_sel_e'(wr_sel) == SEL_CTRL);
  assign wr_tval   = wr_en & (reg_sel_e'(wr_sel) == SEL_TVAL);
  assign unused_hi = ^{wr_data[CTRL_W-1:TVAL_W], wr_data[TVAL_W-1:LIVE_W], wr_data[STAT_BIT]};

  ptimer_ctrl_bits u_bits (
    .clk         (clk),
    .rst_n       (rst_s),
    .wr_ctrl     (wr_ctrl),
    .wr_en_bit   (wr_data[EN_BIT]),
    .wr_mask_bit (wr_data[MASK_BIT]),
    .en_q        (ctrl_en),
    .mask_q      (ctrl_mask)
  );

  ptimer_downcount #(.W(TVAL_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_s),
    .load     (wr_tval),
    .load_val (wr_data[TVAL_W-1:0]),
    .tick     (tick),
    .val_q    (tval_q)
  );

  ptimer_irq_out #(.W(TVAL_W)) u_irq (
    .clk    (clk),
    .rst_n  (rst_s),
    .en     (ctrl_en),
    .mask   (ctrl_mask),
    .val    (tval_q),
    .status (stat),
    .irq_q  (irq_out)
  );

  always_comb begin
    if (reg_sel_e'(rd_sel) == SEL_TVAL)
      rd_data = {{EXT_W{tval_q[TVAL_W-1]}}, tval_q};
    else
      rd_data = {{RSV_W{1'b0}}, stat, ctrl_mask, ctrl_en};
  end
endmodule

// File: rtl/ptimer_ctrl_chk.sv
module ptimer_ctrl_chk (
  input logic        clk,
  input logic        rst_s,
  input logic        tick,
  input logic        wr_en,
  input logic        wr_sel,
  input logic [63:0] wr_data,
  input logic        rd_sel,
  input logic [63:0] rd_data,
  input logic        irq_out,
  input logic        ctrl_en,
  input logic        ctrl_mask,
  input logic [31:0] tval_q
);
  a_r2_rsv_zero: assert property (@(posedge clk) disable iff (!rst_s)
    !rd_sel |-> rd_data[63:3] == 61'd0);

  a_r4_status: assert property (@(posedge clk) disable iff (!rst_s)
    (!rd_sel && ctrl_en) |-> rd_data[2] == ($signed(tval_q) <= 32'sd0));

  a_r5_irq_late: assert property (@(posedge clk) disable iff (!rst_s)
    (ctrl_en && !ctrl_mask && $signed(tval_q) <= 32'sd0) |=> irq_out);

  a_r6_irq_off: assert property (@(posedge clk) disable iff (!rst_s)
    !ctrl_en |=> !irq_out);

  a_r6_stat_off: assert property (@(posedge clk) disable iff (!rst_s)
    (!rd_sel && !ctrl_en) |-> !rd_data[2]);

  a_r7_load: assert property (@(posedge clk) disable iff (!rst_s)
    (wr_en && wr_sel) |=> tval_q == $past(wr_data[31:0]));

  a_r8_tick: assert property (@(posedge clk) disable iff (!rst_s)
    (tick && !(wr_en && wr_sel)) |=> tval_q == $past(tval_q) - 32'd1);
endmodule

bind ptimer_ctrl ptimer_ctrl_chk u_chk (
  .clk       (clk),
  .rst_s     (rst_s),
  .tick      (tick),
  .wr_en     (wr_en),
  .wr_sel    (wr_sel),
  .wr_data   (wr_data),
  .rd_sel    (rd_sel),
  .rd_data   (rd_data),
  .irq_out   (irq_out),
  .ctrl_en   (ctrl_en),
  .ctrl_mask (ctrl_mask),
  .tval_q    (tval_q)
);

// File: tb/tb_ptimer_ctrl.sv
module tb_ptimer_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [63:0] wr_data = '0;
  logic        rd_sel = 1'b0;
  logic [63:0] rd_data;
  logic        irq_out;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  ptimer_ctrl dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [63:0] d, input logic tk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d; tick = tk;
    step();
    wr_en = 1'b0; tick = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [63:0] v);
    rd_sel = sel;
    #1;
    v = rd_data;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      step();
    end
    tick = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [63:0] v;
    logic [31:0] pts [7];
    pts = '{32'd5, 32'd1, 32'd0, 32'hFFFFFFFF, 32'hFFFFFF9C, 32'h7FFFFFFF, 32'h80000000};
    @(negedge clk);
    step();
    rst_n = 1'b1;
    step(); step(); step();

    // R1 reset state
    rd(1'b0, v); chk("R1 ctrl", v, 64'd0);
    rd(1'b1, v); chk("R1 tval", v, 64'd0);
    chk("R1 irq", {63'd0, irq_out}, 64'd0);

    // R2 reserved bits, tval=0, all ones written
    wr(1'b0, '1, 1'b0);
    rd(1'b0, v); chk("R2 rsv zero", v, 64'h7);
    step();
    chk("R2 irq masked", {63'd0, irq_out}, 64'd0);

    // R3 bit2 write ignored
    wr(1'b1, 64'd5, 1'b0);
    wr(1'b0, 64'h4, 1'b0);
    rd(1'b0, v); chk("R3 bit2 only", v, 64'h0);
    wr(1'b0, 64'h5, 1'b0);
    rd(1'b0, v); chk("R3 bit2 ignored", v, 64'h1);
    step();
    chk("R3 irq", {63'd0, irq_out}, 64'd0);

    // R4/R5/R6 sweep
    for (int p = 0; p < 7; p++) begin
      for (int m = 0; m < 2; m++) begin
        for (int e = 0; e < 2; e++) begin
          logic cond;
          cond = $signed(pts[p]) <= 0;
          wr(1'b1, {32'd0, pts[p]}, 1'b0);
          wr(1'b0, {62'd0, m[0], e[0]}, 1'b0);
          rd(1'b0, v);
          if (e == 1) chk("R4 status", {63'd0, v[2]}, {63'd0, cond});
          else        chk("R6 status", {63'd0, v[2]}, 64'd0);
          step();
          if (e == 1) chk("R5 irq", {63'd0, irq_out}, {63'd0, cond & ~m[0]});
          else        chk("R6 irq", {63'd0, irq_out}, 64'd0);
        end
      end
    end

    // R5 timing: irq one cycle after condition
    wr(1'b0, 64'h1, 1'b0);
    wr(1'b1, 64'd1, 1'b0);
    step();
    chk("R5 pre", {63'd0, irq_out}, 64'd0);
    ticks(1);
    rd(1'b0, v); chk("R5 status now", {63'd0, v[2]}, 64'd1);
    chk("R5 irq not yet", {63'd0, irq_out}, 64'd0);
    step();
    chk("R5 irq next", {63'd0, irq_out}, 64'd1);

    // R8 counting while disabled
    wr(1'b0, 64'h0, 1'b0);
    wr(1'b1, 64'd10, 1'b0);
    ticks(7);
    rd(1'b1, v); chk("R8 disabled count", v, 64'd3);
    ticks(5);
    rd(1'b1, v); chk("R8 below zero", v, 64'hFFFFFFFFFFFFFFFE);
    wr(1'b1, 64'h80000000, 1'b0);
    ticks(1);
    rd(1'b1, v); chk("R8 wrap", v, 64'h000000007FFFFFFF);

    // R7 sign extension and upper write bits ignored
    wr(1'b1, 64'hABCD0000_FFFFFFFE, 1'b0);
    rd(1'b1, v); chk("R7 sext", v, 64'hFFFFFFFFFFFFFFFE);
    wr(1'b1, 64'h12345678_00001234, 1'b0);
    rd(1'b1, v); chk("R7 load", v, 64'h1234);

    // R9 load wins over tick
    wr(1'b1, 64'd100, 1'b1);
    rd(1'b1, v); chk("R9 priority", v, 64'd100);

    // R1 reset again mid-run
    wr(1'b0, 64'h1, 1'b0);
    rst_n = 1'b0;
    #1;
    rd(1'b0, v); chk("R1 async ctrl", v, 64'd0);
    step();
    rst_n = 1'b1;
    step(); step(); step();
    rd(1'b1, v); chk("R1 async tval", v, 64'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule